// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Source Selection

This block is a general-purpose I/O controller for a parameterised number of pins (32 by default). Software sees a small set of 32-bit registers on a simple memory-mapped bus. Pin n always sits at data bit 31-n, so pin 0 is the most significant bit. For each pin, software sets an output level and a drive enable. It also picks where the pad's output value comes from and where its drive enable comes from. Each of these two choices is a two-bit field: value 0 keeps the GPIO register, and values 1 to 3 route one of three alternate peripheral signals to the pad.

A per-pin open-drain switch changes how the chosen signals reach the pad. In that mode the pad drives a low level when its chosen value is 0, and it lets go of the pad when the value is 1. The pad inputs pass through a two-stage synchroniser and can be read back through a read-only register.

Register reads are combinational on the address. A write lands on the clock edge where it is sampled. The pad outputs follow the new register contents straight after that edge.

Top module: `gpio_pinmux`

## Requirements
- R1: After a synchronous reset every register reads 0, padOe is all zero and padOut is all zero, whatever the alternate inputs are.
- R2: Register map, with word-aligned byte offsets: 0x00 output data, 0x04 drive enable, 0x18 open-drain enable. Pin n occupies bit 31-n in each of these. A written value reads back, and bits with no pin behind them read 0.
- R3: Output-source selects live at 0x08 (low half) and 0x0C (high half). Drive-source selects live at 0x10 (low half) and 0x14 (high half). Pin n below NUM_PINS/2 uses bits [31-2n:30-2n] of the low register. Pin n at or above NUM_PINS/2 uses the same position in the high register, computed with n-NUM_PINS/2.
- R4: A pin's selected output value is the output data bit when its output-source field is 0. When the field is k, with k from 1 to 3, the value is altOut[(k-1)*NUM_PINS+n]. The pads reflect a write in the cycle after the write edge.
- R5: A pin's selected drive enable is the drive-enable bit when its drive-source field is 0. When the field is k, with k from 1 to 3, the enable is altEn[(k-1)*NUM_PINS+n].
- R6: With its open-drain bit set, a pin has padOut = 0, and padOe = selected enable AND NOT selected output value.
- R7: With its open-drain bit clear, a pin has padOut = selected output value and padOe = selected enable.
- R8: Offset 0x1C reads padIn, pin n at bit 31-n, two rising edges after padIn changes. Writing to 0x1C changes nothing.
- R9: An offset of 0x20 or above, or any offset that is not a multiple of 4, reads 0. A write to such an offset leaves all register state and all pad outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | Access is a write when high |
| busAddr | input | ADDR_W | Byte address within the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| altOut | input | 3*NUM_PINS | Alternate output values; slice k-1 serves select value k |
| altEn | input | 3*NUM_PINS | Alternate drive enables; slice k-1 serves select value k |
| padIn | input | NUM_PINS | Asynchronous pad input levels |
| padOut | output | NUM_PINS | Value driven to each pad |
| padOe | output | NUM_PINS | Pad driver enable |

## Verification
The bench builds the block with NUM_PINS = 8, which gives four pins per select register. At that size it can step through 256 configurations in which every pin goes through all sixteen output-source and drive-source pairs. Open-drain, data, enable and alternate-input patterns also vary in those configurations, and the bench predicts both pad vectors for each one from the requirement formulas. The same small build leaves unused upper register bits, so the bench can show that they read 0. It also exercises the synchroniser latency, misaligned addresses and addresses beyond the map.

// File: rtl/gpio_pinmux_pkg.sv
`timescale 1ns/1ps
package gpio_pinmux_pkg;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 2;
  localparam int NUM_ALT = 3;

  // word indices inside the register window
  localparam int WORD_OUT  = 0;
  localparam int WORD_DRV  = 1;
  localparam int WORD_OSLO = 2;
  localparam int WORD_OSHI = 3;
  localparam int WORD_TSLO = 4;
  localparam int WORD_TSHI = 5;
  localparam int WORD_OD   = 6;
  localparam int WORD_IN   = 7;

  typedef enum logic [3:0] {
    RD_NONE, RD_OUT, RD_DRV, RD_OSLO, RD_OSHI, RD_TSLO, RD_TSHI, RD_OD, RD_IN
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrDrv;
    logic   wrOsLo;
    logic   wrOsHi;
    logic   wrTsLo;
    logic   wrTsHi;
    logic   wrOd;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/gpio_pinmux_ctrl.sv
`timescale 1ns/1ps
module gpio_pinmux_ctrl
  import gpio_pinmux_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic             wrEn;
  logic [IDX_W-1:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busSel & busWrite & aligned;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (aligned) begin
      case (int'(wordIdx))
        WORD_OUT:  begin strobe.wrOut  = wrEn; strobe.rdSel = RD_OUT;  end
        WORD_DRV:  begin strobe.wrDrv  = wrEn; strobe.rdSel = RD_DRV;  end
        WORD_OSLO: begin strobe.wrOsLo = wrEn; strobe.rdSel = RD_OSLO; end
        WORD_OSHI: begin strobe.wrOsHi = wrEn; strobe.rdSel = RD_OSHI; end
        WORD_TSLO: begin strobe.wrTsLo = wrEn; strobe.rdSel = RD_TSLO; end
        WORD_TSHI: begin strobe.wrTsHi = wrEn; strobe.rdSel = RD_TSHI; end
        WORD_OD:   begin strobe.wrOd   = wrEn; strobe.rdSel = RD_OD;   end
        WORD_IN:   strobe.rdSel = RD_IN;   // read-only
        default:   strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pinmux_regs.sv
`timescale 1ns/1ps
module gpio_pinmux_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  regStrobe_t                     strobe,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [NUM_PINS-1:0]            padIn,
  output logic [DATA_W-1:0]              busRdata,
  output logic [NUM_PINS-1:0]            outBits,
  output logic [NUM_PINS-1:0]            drvBits,
  output logic [NUM_PINS-1:0]            odBits,
  output logic [NUM_PINS-1:0][SEL_W-1:0] outSrc,
  output logic [NUM_PINS-1:0][SEL_W-1:0] drvSrc,
  output logic [NUM_PINS-1:0]            inSync
);
  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] inMeta;
  logic [DATA_W-1:0]   imgOut, imgDrv, imgOd, imgIn;
  logic [DATA_W-1:0]   imgOsLo, imgOsHi, imgTsLo, imgTsHi;

  // register writes; pin n sits at bit DATA_W-1-n
  always_ff @(posedge clk) begin
    if (rst) begin
      outBits <= '0;
      drvBits <= '0;
      odBits  <= '0;
      outSrc  <= '0;
      drvSrc  <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobe.wrOut) outBits[i] <= busWdata[DATA_W-1-i];
        if (strobe.wrDrv) drvBits[i] <= busWdata[DATA_W-1-i];
        if (strobe.wrOd)  odBits[i]  <= busWdata[DATA_W-1-i];
        if (i < HALF) begin
          if (strobe.wrOsLo) outSrc[i] <= busWdata[DATA_W-1-2*(i%HALF) -: SEL_W];
          if (strobe.wrTsLo) drvSrc[i] <= busWdata[DATA_W-1-2*(i%HALF) -: SEL_W];
        end else begin
          if (strobe.wrOsHi) outSrc[i] <= busWdata[DATA_W-1-2*(i%HALF) -: SEL_W];
          if (strobe.wrTsHi) drvSrc[i] <= busWdata[DATA_W-1-2*(i%HALF) -: SEL_W];
        end
      end
    end
  end

  // two-stage pad input synchroniser
  always_ff @(posedge clk) begin
    if (rst) begin
      inMeta <= '0;
      inSync <= '0;
    end else begin
      inMeta <= padIn;
      inSync <= inMeta;
    end
  end

  // read images
  always_comb begin
    imgOut  = '0;
    imgDrv  = '0;
    imgOd   = '0;
    imgIn   = '0;
    imgOsLo = '0;
    imgOsHi = '0;
    imgTsLo = '0;
    imgTsHi = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      imgOut[DATA_W-1-i] = outBits[i];
      imgDrv[DATA_W-1-i] = drvBits[i];
      imgOd[DATA_W-1-i]  = odBits[i];
      imgIn[DATA_W-1-i]  = inSync[i];
      if (i < HALF) begin
        imgOsLo[DATA_W-1-2*(i%HALF) -: SEL_W] = outSrc[i];
        imgTsLo[DATA_W-1-2*(i%HALF) -: SEL_W] = drvSrc[i];
      end else begin
        imgOsHi[DATA_W-1-2*(i%HALF) -: SEL_W] = outSrc[i];
        imgTsHi[DATA_W-1-2*(i%HALF) -: SEL_W] = drvSrc[i];
      end
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_OUT:  busRdata = imgOut;
      RD_DRV:  busRdata = imgDrv;
      RD_OSLO: busRdata = imgOsLo;
      RD_OSHI: busRdata = imgOsHi;
      RD_TSLO: busRdata = imgTsLo;
      RD_TSHI: busRdata = imgTsHi;
      RD_OD:   busRdata = imgOd;
      RD_IN:   busRdata = imgIn;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pinmux_pads.sv
`timescale 1ns/1ps
module gpio_pinmux_pads
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]            outBits,
  input  logic [NUM_PINS-1:0]            drvBits,
  input  logic [NUM_PINS-1:0]            odBits,
  input  logic [NUM_PINS-1:0][SEL_W-1:0] outSrc,
  input  logic [NUM_PINS-1:0][SEL_W-1:0] drvSrc,
  input  logic [NUM_ALT*NUM_PINS-1:0]    altOut,
  input  logic [NUM_ALT*NUM_PINS-1:0]    altEn,
  output logic [NUM_PINS-1:0]            padOut,
  output logic [NUM_PINS-1:0]            padOe
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic selOut;
    logic selEn;

    always_comb begin
      case (outSrc[n])
        2'd0:    selOut = outBits[n];
        2'd1:    selOut = altOut[n];
        2'd2:    selOut = altOut[NUM_PINS + n];
        default: selOut = altOut[2*NUM_PINS + n];
      endcase
    end

    always_comb begin
      case (drvSrc[n])
        2'd0:    selEn = drvBits[n];
        2'd1:    selEn = altEn[n];
        2'd2:    selEn = altEn[NUM_PINS + n];
        default: selEn = altEn[2*NUM_PINS + n];
      endcase
    end

    // open drain: pull low on a zero, release on a one
    assign padOut[n] = odBits[n] ? 1'b0 : selOut;
    assign padOe[n]  = odBits[n] ? (selEn & ~selOut) : selEn;
  end
endmodule

// File: rtl/gpio_pinmux.sv
`timescale 1ns/1ps
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busSel,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [3*NUM_PINS-1:0]       altOut,
  input  logic [3*NUM_PINS-1:0]       altEn,
  input  logic [NUM_PINS-1:0]         padIn,
  output logic [NUM_PINS-1:0]         padOut,
  output logic [NUM_PINS-1:0]         padOe
);
  regStrobe_t                     strobe;
  logic [NUM_PINS-1:0]            outBits;
  logic [NUM_PINS-1:0]            drvBits;
  logic [NUM_PINS-1:0]            odBits;
  logic [NUM_PINS-1:0][SEL_W-1:0] outSrc;
  logic [NUM_PINS-1:0][SEL_W-1:0] drvSrc;
  logic [NUM_PINS-1:0]            inSync;

  gpio_pinmux_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_pinmux_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .busWdata (busWdata),
    .padIn    (padIn),
    .busRdata (busRdata),
    .outBits  (outBits),
    .drvBits  (drvBits),
    .odBits   (odBits),
    .outSrc   (outSrc),
    .drvSrc   (drvSrc),
    .inSync   (inSync)
  );

  gpio_pinmux_pads #(.NUM_PINS(NUM_PINS)) u_pads (
    .outBits (outBits),
    .drvBits (drvBits),
    .odBits  (odBits),
    .outSrc  (outSrc),
    .drvSrc  (drvSrc),
    .altOut  (altOut),
    .altEn   (altEn),
    .padOut  (padOut),
    .padOe   (padOe)
  );
endmodule

// File: rtl/gpio_pinmux_chk.sv
`timescale 1ns/1ps
module gpio_pinmux_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] outBits,
  input logic [NUM_PINS-1:0] drvBits,
  input logic [NUM_PINS-1:0] odBits,
  input logic [NUM_PINS-1:0] inSync
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= 2'd0;
    else if (sinceRst != 3)  sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic [NUM_PINS-1:0] pinsOf(input logic [31:0] w);
    for (int n = 0; n < NUM_PINS; n++) pinsOf[n] = w[31-n];
  endfunction

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd0) |-> (padOe == '0));

  // R2
  data_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && busAddr == '0) |=> (outBits == pinsOf($past(busWdata))));

  // R6
  od_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((padOut & odBits) == '0));

  // R8
  in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (inSync == $past(padIn, 2)));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && (int'(busAddr[ADDR_W-1:2]) >= 7 || busAddr[1:0] != 2'b00))
      |=> ($stable(outBits) && $stable(drvBits) && $stable(odBits)));
endmodule

bind gpio_pinmux gpio_pinmux_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .outBits  (outBits),
  .drvBits  (drvBits),
  .odBits   (odBits),
  .inSync   (inSync)
);

// File: tb/tb_gpio_pinmux.sv
`timescale 1ns/1ps
module tb_gpio_pinmux;
  localparam int NP   = 8;
  localparam int HALF = NP / 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          busSel, busWrite;
  logic [6:0]    busAddr;
  logic [31:0]   busWdata, busRdata;
  logic [3*NP-1:0] altOut, altEn;
  logic [NP-1:0] padIn, padOut, padOe;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  gpio_pinmux #(.NUM_PINS(NP), .ADDR_W(7)) dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .altOut(altOut), .altEn(altEn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  localparam logic [31:0] PIN_MASK = ~(32'hFFFF_FFFF >> NP);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [31:0] pinWord(input logic [NP-1:0] v);
    logic [31:0] w = '0;
    for (int n = 0; n < NP; n++) w[31-n] = v[n];
    return w;
  endfunction

  function automatic logic [31:0] selWord(input logic [NP-1:0][1:0] s, input int h);
    logic [31:0] w = '0;
    for (int j = 0; j < HALF; j++) w[31-2*j -: 2] = s[h*HALF + j];
    return w;
  endfunction

  logic [31:0]          rd;
  logic [NP-1:0][1:0]   osv, tsv;
  logic [NP-1:0]        odv, outv, drvv, expOut, expOe;
  logic [31:0]          saveOut, saveDrv, saveOd;

  initial begin
    rst = 1'b1; busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    altOut = '1; altEn = '1; padIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    #1 check("R1", "padOe after reset", 32'(padOe), 32'h0);
    check("R1", "padOut after reset", 32'(padOut), 32'h0);
    for (int a = 0; a < 8; a++) begin
      busRd(7'(a*4), rd);
      check("R1", $sformatf("reg 0x%0h after reset", a*4), rd, 32'h0);
    end

    // R2: readback of pin-bit registers, unused bits read 0
    busWr(7'h00, 32'hA5C3_1234); busRd(7'h00, rd);
    check("R2", "data readback", rd, 32'hA5C3_1234 & PIN_MASK);
    busWr(7'h04, 32'h5A3C_FFFF); busRd(7'h04, rd);
    check("R2", "drive readback", rd, 32'h5A3C_FFFF & PIN_MASK);
    busWr(7'h18, 32'hF00F_0F0F); busRd(7'h18, rd);
    check("R2", "open-drain readback", rd, 32'hF00F_0F0F & PIN_MASK);

    // R3: select field readback
    busWr(7'h08, 32'hE4FF_FFFF); busRd(7'h08, rd);
    check("R3", "out-src low", rd, 32'hE400_0000);
    busWr(7'h0C, 32'h1BFF_0000); busRd(7'h0C, rd);
    check("R3", "out-src high", rd, 32'h1B00_0000);
    busWr(7'h10, 32'h9C00_0001); busRd(7'h10, rd);
    check("R3", "drv-src low", rd, 32'h9C00_0000);
    busWr(7'h14, 32'h63AA_AAAA); busRd(7'h14, rd);
    check("R3", "drv-src high", rd, 32'h6300_0000);

    // R4 R5 R6 R7: sweep of pin configurations
    for (int k = 0; k < 256; k++) begin
      for (int n = 0; n < NP; n++) begin
        osv[n] = 2'((k + n) % 4);
        tsv[n] = 2'((k / 4 + 3 * n) % 4);
      end
      odv  = NP'((k * 37 + 5) % 256);
      outv = NP'((k * 73 + 11) % 256);
      drvv = NP'((k * 29 + 3) % 256);
      busWr(7'h00, pinWord(outv));
      busWr(7'h04, pinWord(drvv));
      busWr(7'h18, pinWord(odv));
      busWr(7'h08, selWord(osv, 0));
      busWr(7'h0C, selWord(osv, 1));
      busWr(7'h10, selWord(tsv, 0));
      @(negedge clk);
      altOut = 24'((k * 40503 + 12345) % 16777216);
      altEn  = 24'((k * 9973 + 777) % 16777216);
      busWr(7'h14, selWord(tsv, 1));
      for (int n = 0; n < NP; n++) begin
        logic so, se;
        so = (osv[n] == 0) ? outv[n] : altOut[(int'(osv[n]) - 1) * NP + n];
        se = (tsv[n] == 0) ? drvv[n] : altEn[(int'(tsv[n]) - 1) * NP + n];
        if (odv[n]) begin expOut[n] = 1'b0; expOe[n] = se & ~so; end  // R6
        else        begin expOut[n] = so;   expOe[n] = se;       end  // R7
      end
      #1;
      check("R4/R6/R7", $sformatf("padOut cfg %0d", k), 32'(padOut), 32'(expOut));
      check("R5/R6/R7", $sformatf("padOe cfg %0d", k), 32'(padOe), 32'(expOe));
    end

    // R8: two-edge input latency, read-only
    @(negedge clk);
    padIn = 8'hA5; busAddr = 7'h1C;
    #1 check("R8", "input at 0 edges", busRdata, 32'h0);
    @(negedge clk); #1 check("R8", "input at 1 edge", busRdata, 32'h0);
    @(negedge clk); #1 check("R8", "input at 2 edges", busRdata, pinWord(8'hA5));
    busWr(7'h1C, 32'hFFFF_FFFF); busRd(7'h1C, rd);
    check("R8", "input after write", rd, pinWord(8'hA5));

    // R9: unmapped and misaligned offsets
    busRd(7'h00, saveOut); busRd(7'h04, saveDrv); busRd(7'h18, saveOd);
    busWr(7'h20, 32'hFFFF_FFFF);
    busWr(7'h40, 32'hFFFF_FFFF);
    busWr(7'h01, ~saveOut);
    busWr(7'h05, ~saveDrv);
    busWr(7'h1A, ~saveOd);
    busRd(7'h00, rd); check("R9", "data unchanged", rd, saveOut);
    busRd(7'h04, rd); check("R9", "drive unchanged", rd, saveDrv);
    busRd(7'h18, rd); check("R9", "open-drain unchanged", rd, saveOd);
    busRd(7'h20, rd); check("R9", "read 0x20", rd, 32'h0);
    busRd(7'h40, rd); check("R9", "read 0x40", rd, 32'h0);
    busRd(7'h7C, rd); check("R9", "read 0x7C", rd, 32'h0);
    busRd(7'h02, rd); check("R9", "read misaligned", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule